// File: doc/BRIEF.md
# Seven-Level Interrupt Priority Mask Logic

This block sits between a group of interrupt request lines and a processor core. Each request line is bound at build time to one of seven priority levels. The block picks the most urgent active request, presents it as a 3-bit encoded level together with a vector number, and compares that level against the 3-bit interrupt mask taken from the processor status register. It raises a pending flag when the core should take the interrupt.

Levels 1 to 6 are level-sensitive and maskable. Level 7 is the non-maskable level. A line bound to level 7 is captured on its rising edge into a sticky latch. That latch is released only when the core acknowledges level 7 while the latched source is the one on offer. The core signals an acknowledge with a one-cycle strobe that carries the level it is servicing.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, and whenever no request is active, the encoded level is 0, the vector is 0 and the pending flag is low.
- R2: When lines at different levels are active, the encoded level is the highest of those levels (7 highest, 1 lowest).
- R3: When several active lines share the winning level, the vector names the lowest-numbered of them.
- R4: For a winning level from 1 to 6, the pending flag is high only when that level is strictly greater than the mask. At or below the mask it stays low, while the level and vector are still presented.
- R5: A level-7 request raises the pending flag whatever the mask value, including a mask of 7.
- R6: A level-7 line that stays high after its acknowledge does not raise a new request. Only a fresh low-to-high transition captures it again.
- R7: A captured level-7 request stays presented after its line goes low, until it is acknowledged.
- R8: An acknowledge strobe whose level field is not 7 leaves a captured level-7 request in place.
- R9: Level and vector come from a common register stage, one clock after the request is seen. The vector is VEC_BASE plus the source index (default VEC_BASE = 64).
- R10: A line at level 1 to 6 that goes low stops being presented on the next update, with no acknowledge.
- R11: The pending flag follows a change of the mask without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Raw request lines, one per source |
| sr_mask | input | 3 | Current interrupt mask from the status register |
| ack | input | 1 | One-cycle acknowledge strobe from the core |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Encoded level of the winning request, 0 when none |
| irq_pending | output | 1 | Request should be taken by the core |
| irq_vector | output | VEC_W | Vector number of the winning source, 0 when none |

## Verification
The bench sets the mask equal to the request level. A design that compares with greater-or-equal would raise pending there and fail. It holds the level-7 line high across an acknowledge, which catches a latch that re-arms from the level rather than the edge. It also drops the line before the acknowledge, which catches a latch that merely follows the input. An acknowledge carrying level 6 is sent while level 7 is latched, to expose a clear that ignores the level field. Two sources share a level, so an encoder that lets the higher index win shows up as the wrong vector.

// File: rtl/irq_mask_pkg.sv
// Package: shared types and helpers for the interrupt priority mask logic.
// Assumes levels are 3 bits with 7 as the non-maskable level.
package irq_mask_pkg;
    typedef logic [2:0] prio_t;

    localparam prio_t NMI_LEVEL = 3'd7;

    // Extract the level bound to source idx from a packed level table.
    function automatic prio_t src_level(input logic [255:0] table_bits, input int idx);
        return table_bits[idx*3 +: 3];
    endfunction
endpackage

// File: rtl/irq_nmi_capture.sv
// Rising-edge capture for one non-maskable request line.
// Sets on a low-to-high transition, clears on a qualified acknowledge;
// a new edge in the same cycle as the clear wins. Assumes a synchronous input.
module irq_nmi_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic clr,
    output logic held
);
    logic prev_q;

    // Remember last input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw_in;
    end

    // Sticky latch: set by rising edge, released by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 held <= 1'b0;
        else if (raw_in && !prev_q) held <= 1'b1;
        else if (clr)               held <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_encode.sv
// Combinational priority encoder: finds the highest level among active
// sources; on a tie the lowest source index wins. Level 0 means none.
module irq_prio_encode #(
    parameter int              N_SRC     = 8,
    parameter logic [255:0]    SRC_LEVEL = '0,
    localparam int             IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]         active,
    output irq_mask_pkg::prio_t      best_lvl,
    output logic [IDX_W-1:0]         best_idx
);
    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (active[i] && (irq_mask_pkg::src_level(SRC_LEVEL, i) > best_lvl)) begin
                best_lvl = irq_mask_pkg::src_level(SRC_LEVEL, i);
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Top: seven-level interrupt priority mask logic.
// Level-7 sources go through edge capture; levels 1-6 are used as levels.
// Winning level, vector and source index are registered together; the
// pending flag compares the registered level against the live mask.
// Assumes request lines are synchronous to clk and SRC_LEVEL entries are 1..7.
module irq_mask_ctrl #(
    parameter int           N_SRC     = 8,
    parameter int           VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'd64,
    parameter logic [255:0] SRC_LEVEL = 256'b011111110101100011010001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [2:0]       sr_mask,
    input  logic             ack,
    input  logic [2:0]       ack_level,
    output logic [2:0]       irq_level,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vector
);
    import irq_mask_pkg::*;

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] active;
    prio_t            enc_lvl;
    logic [IDX_W-1:0] enc_idx;
    prio_t            lvl_q;
    logic [IDX_W-1:0] src_q;
    logic [VEC_W-1:0] vec_q;
    logic             nmi_ack;

    // Acknowledge that releases the latched level-7 source on offer.
    assign nmi_ack = ack && (ack_level == NMI_LEVEL) && (lvl_q == NMI_LEVEL);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (src_level(SRC_LEVEL, g) == NMI_LEVEL) begin : g_nmi
            irq_nmi_capture u_cap (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_in (irq_req[g]),
                .clr    (nmi_ack && (src_q == IDX_W'(g))),
                .held   (active[g])
            );
        end else begin : g_lvl
            assign active[g] = irq_req[g];
        end
    end

    irq_prio_encode #(
        .N_SRC     (N_SRC),
        .SRC_LEVEL (SRC_LEVEL)
    ) u_enc (
        .active   (active),
        .best_lvl (enc_lvl),
        .best_idx (enc_idx)
    );

    // Register level, source and vector in one stage so they always match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            src_q <= '0;
            vec_q <= '0;
        end else begin
            lvl_q <= enc_lvl;
            src_q <= enc_idx;
            vec_q <= (enc_lvl == '0) ? '0 : VEC_BASE + VEC_W'(enc_idx);
        end
    end

    // Continuous mask comparison; level 7 bypasses the mask.
    always_comb begin
        irq_pending = (lvl_q == NMI_LEVEL) || (lvl_q > sr_mask);
    end

    assign irq_level  = lvl_q;
    assign irq_vector = vec_q;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Checker for irq_mask_ctrl, attached by bind. Watches ports only.
module irq_mask_ctrl_chk #(
    parameter int           N_SRC     = 8,
    parameter int           VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'd64,
    parameter logic [255:0] SRC_LEVEL = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_req,
    input logic [2:0]       sr_mask,
    input logic [2:0]       irq_level,
    input logic             irq_pending,
    input logic [VEC_W-1:0] irq_vector
);
    p_nmi_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd7) |-> irq_pending);

    p_mask_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd7 && irq_level <= sr_mask) |-> !irq_pending);

    p_idle_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd0) |-> (irq_vector == '0 && !irq_pending));

    p_vector_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd0) |-> (irq_vector >= VEC_BASE && irq_vector < VEC_BASE + VEC_W'(N_SRC)));

    for (genvar g = 0; g < N_SRC; g++) begin : g_lvl_chk
        if (SRC_LEVEL[g*3 +: 3] != 3'd7) begin : g_m
            p_highest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(irq_req[g])) |-> (irq_level >= SRC_LEVEL[g*3 +: 3]));
        end
    end
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .N_SRC     (N_SRC),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .SRC_LEVEL (SRC_LEVEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .sr_mask     (sr_mask),
    .irq_level   (irq_level),
    .irq_pending (irq_pending),
    .irq_vector  (irq_vector)
);

// File: tb/tb_irq_mask_ctrl.sv
// Directed bench: one task per scenario. Default source map:
// src0=L1 src1=L2 src2=L3 src3=L4 src4=L5 src5=L6 src6=L7 src7=L3, base 64.
`timescale 1ns/1ps
module tb_irq_mask_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic [2:0] sr_mask = '0;
    logic       ack = 1'b0;
    logic [2:0] ack_level = '0;
    logic [2:0] irq_level;
    logic       irq_pending;
    logic [7:0] irq_vector;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_mask_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sr_mask(sr_mask),
        .ack(ack), .ack_level(ack_level), .irq_level(irq_level),
        .irq_pending(irq_pending), .irq_vector(irq_vector)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int lvl, input int vec, input int pend);
        chk({req, " level"}, irq_level, lvl);
        chk({req, " vector"}, irq_vector, vec);
        chk({req, " pending"}, irq_pending, pend);
    endtask

    task automatic do_ack(input logic [2:0] lv);
        ack = 1'b1; ack_level = lv;
        step(1);
        ack = 1'b0; ack_level = '0;
    endtask

    task automatic t_reset_r1();
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_priority_r2();
        sr_mask = 3'd0;
        irq_req = 8'b0000_1011; step(2);
        expect_out("R2", 4, 67, 1);
        irq_req = 8'b0011_1011; step(2);
        expect_out("R2", 6, 69, 1);
        irq_req = '0; step(2);
    endtask

    task automatic t_tie_r3();
        irq_req = 8'b1000_0100; step(2);
        expect_out("R3", 3, 66, 1);
        irq_req = 8'b1000_0000; step(2);
        expect_out("R3", 3, 71, 1);
        irq_req = '0; step(2);
    endtask

    task automatic t_mask_r4();
        irq_req = 8'b0010_0000; sr_mask = 3'd6; step(2);
        expect_out("R4", 6, 69, 0);
        sr_mask = 3'd7; step(1);
        chk("R4 pending mask7", irq_pending, 0);
        sr_mask = 3'd5; step(1);
        chk("R4 pending mask5", irq_pending, 1);
        irq_req = '0; sr_mask = 3'd0; step(2);
    endtask

    task automatic t_mask_comb_r11();
        irq_req = 8'b0000_1000; sr_mask = 3'd0; step(2);
        sr_mask = 3'd4; #1;
        chk("R11 pending after mask raise", irq_pending, 0);
        sr_mask = 3'd3; #1;
        chk("R11 pending after mask lower", irq_pending, 1);
        irq_req = '0; sr_mask = 3'd0; step(2);
    endtask

    task automatic t_nmi_hold_r5_r6();
        sr_mask = 3'd7;
        irq_req = 8'b0100_0000; step(2);
        expect_out("R5", 7, 70, 1);
        do_ack(3'd7); step(2);
        expect_out("R6 held line no retrigger", 0, 0, 0);
        step(3);
        chk("R6 still idle", irq_level, 0);
        irq_req = '0; step(1);
        irq_req = 8'b0100_0000; step(2);
        expect_out("R6 new edge", 7, 70, 1);
        do_ack(3'd7); irq_req = '0; step(2);
        chk("R6 cleared", irq_level, 0);
        sr_mask = 3'd0;
    endtask

    task automatic t_nmi_sticky_r7_r8();
        irq_req = 8'b0110_0000; step(1);
        irq_req = 8'b0010_0000; step(3);
        expect_out("R7 after line low", 7, 70, 1);
        do_ack(3'd6); step(2);
        expect_out("R8 wrong ack level", 7, 70, 1);
        do_ack(3'd7); step(2);
        expect_out("R8 after level-7 ack", 6, 69, 1);
        irq_req = '0; step(2);
    endtask

    task automatic t_timing_r9_r10();
        irq_req = 8'b0001_0000; step(1);
        expect_out("R9 one clock", 5, 68, 1);
        irq_req = '0; step(1);
        expect_out("R10 drop", 0, 0, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset_r1();
        t_priority_r2();
        t_tie_r3();
        t_mask_r4();
        t_mask_comb_r11();
        t_nmi_hold_r5_r6();
        t_nmi_sticky_r7_r8();
        t_timing_r9_r10();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule